// File: doc/BRIEF.md
# Core Tick Timer with Period Match

This block is a per-core tick timer. A 32-bit count advances once per clock while the timer runs. A mode register holds a 2-bit run mode, an interrupt enable, an interrupt pending flag and a 28-bit match period. When the low 28 bits of the count equal the period, the pending flag is set. A level interrupt follows pending while enable is set. Both registers are read and written through a plain register port: a one-bit register select, a write strobe, write data and registered read data.

Software uses the timer in two ways. As a free-running clock source, it reads the count. As an event source, it writes a mode word that holds the continuous code, enable set, and a period equal to the current count plus a delta, cut to 28 bits. To acknowledge an event, software writes the mode word with only the continuous code. This clears pending and enable and leaves the count running. Two further run modes are provided. Restart mode clears the count on a match. One-shot mode freezes the count on a match and falls back to the disabled code.

Top module: `tick_timer`

## Requirements
- R1: After reset the count, the mode register, the read data and the interrupt are all zero.
- R2: Register select 0 addresses the count. A write with select 0 loads the count, and this load takes priority over counting. While the mode is 11 the count then continues upward from the loaded value, and it wraps from 0xFFFFFFFF to 0.
- R3: Mode code 00 is disabled. The count holds its value and no match is detected, even when the period equals the count.
- R4: Register select 1 addresses the mode register, laid out as bits 31:30 mode code, bit 29 enable, bit 28 pending, bits 27:0 period. A match occurs when count[27:0] equals the period while the mode code is not 00. A match sets pending on that clock edge, whatever the value of enable.
- R5: The interrupt output is registered and equals pending AND enable.
- R6: In mode code 11 (continuous) the count increments by one every cycle, including the cycle of a match.
- R7: In mode code 01 (restart) a match clears the count to zero. With period P the count therefore cycles with period P+1.
- R8: In mode code 10 (one-shot) a match holds the count at the matching value and changes the mode code to 00. Enable, pending and period are kept.
- R9: A mode write that holds 1 in bit 28 leaves pending unchanged, and a write that holds 0 in bit 28 clears it. When a match and a clearing write fall on the same edge, pending ends up set.
- R10: Writing 0xC0000000 to the mode register drops the interrupt on that edge and clears enable and pending. The count keeps running.
- R11: Read data is registered. After each edge it holds the selected register as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects the count, 1 selects the mode register |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| irq | output | 1 | Level interrupt, pending AND enable |

## Verification
The assertions assume that the write strobe and select are clean, known values on every edge after reset. They also assume that only one register is written per cycle, which the single select input guarantees. The stimulus changes the port inputs only on falling clock edges and drops the strobe after each single-cycle write. It places every period match at a cycle that can be computed from the loaded count, so that no match meets an unplanned write. The one exception is the one case that deliberately puts a clearing write on the same edge as a match.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TT_OFF     = 2'b00,
    TT_RESTART = 2'b01,
    TT_ONESHOT = 2'b10,
    TT_CONT    = 2'b11
  } tt_mode_e;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);

  // Priority: software load, then restart clear, then increment.
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (clr)  cnt <= '0;
    else if (run)  cnt <= cnt + ONE;
  end
endmodule

// File: rtl/tt_match.sv
module tt_match #(
  parameter int W  = 32,
  parameter int PW = 28
) (
  input  logic [W-1:0]  cnt,
  input  logic [PW-1:0] period,
  input  logic          active,
  output logic          match
);
  // Only the low PW bits of the count take part in the compare.
  assign match = active && (cnt[PW-1:0] == period);
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  input  logic              match,
  output tt_mode_e          mode,
  output logic              ie,
  output logic              ip,
  output logic [W-5:0]      period,
  output logic              irq
);
  localparam int PW = W - 4;

  tt_mode_e       mode_n;
  logic           ie_n, ip_n;
  logic [PW-1:0]  per_n;

  always_comb begin
    mode_n = mode;
    ie_n   = ie;
    ip_n   = ip;
    per_n  = period;
    if (wr) begin
      mode_n = tt_mode_e'(wdata[W-1:W-2]);
      ie_n   = wdata[W-3];
      ip_n   = ip & wdata[W-4];
      per_n  = wdata[PW-1:0];
    end else if (match && mode == TT_ONESHOT) begin
      mode_n = TT_OFF;
    end
    if (match) ip_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= TT_OFF;
      ie     <= 1'b0;
      ip     <= 1'b0;
      period <= '0;
      irq    <= 1'b0;
    end else begin
      mode   <= mode_n;
      ie     <= ie_n;
      ip     <= ip_n;
      period <= per_n;
      irq    <= ip_n & ie_n;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int PW = DATA_W - 4;

  logic [DATA_W-1:0] cnt_q;
  tt_mode_e          mode_q;
  logic              ie_q, ip_q;
  logic [PW-1:0]     period_q;
  logic              match;
  logic              wr_cnt, wr_mode, run, clr;

  assign wr_cnt  = reg_we & ~reg_sel;
  assign wr_mode = reg_we & reg_sel;

  assign clr = (mode_q == TT_RESTART) && match;
  assign run = (mode_q == TT_CONT) ||
               (((mode_q == TT_RESTART) || (mode_q == TT_ONESHOT)) && !match);

  tt_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load(wr_cnt), .load_val(reg_wdata),
    .clr(clr), .run(run), .cnt(cnt_q)
  );

  tt_match #(.W(DATA_W), .PW(PW)) u_match (
    .cnt(cnt_q), .period(period_q), .active(mode_q != TT_OFF), .match(match)
  );

  tt_ctrl #(.W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_mode), .wdata(reg_wdata), .match(match),
    .mode(mode_q), .ie(ie_q), .ip(ip_q), .period(period_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)          reg_rdata <= '0;
    else if (reg_sel) reg_rdata <= {mode_q, ie_q, ip_q, period_q};
    else              reg_rdata <= cnt_q;
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_cnt,
  input logic              wr_mode,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] cnt,
  input logic [1:0]        mode,
  input logic              ie,
  input logic              ip,
  input logic              match,
  input logic              irq
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && mode == 2'b00 && !ip && !ie && !irq));

  assert_off_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !wr_cnt) |=> cnt == $past(cnt));

  assert_off_no_match_R3: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |-> !match);

  assert_match_pends_R4: assert property (@(posedge clk) disable iff (rst)
    match |=> ip);

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (rst)
    (ip && ie) |-> irq);

  assert_cont_steps_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !wr_cnt) |=> cnt == $past(cnt) + ONE);

  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && match && !wr_cnt) |=> cnt == '0);

  assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && match && !wr_cnt && !wr_mode) |=>
      (mode == 2'b00 && cnt == $past(cnt)));

  assert_clear_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && !wdata[DATA_W-4] && !match) |=> !ip);
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_cnt(wr_cnt), .wr_mode(wr_mode),
  .wdata(reg_wdata), .cnt(cnt_q), .mode(mode_q), .ie(ie_q), .ip(ip_q),
  .match(match), .irq(irq)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Vector: start count, period, enable, wait cycles, expected irq,
  // expected count read, expected pending. Mode code is 11 throughout.
  typedef struct packed {
    logic [31:0] c0;
    logic [27:0] per;
    logic        en;
    logic [7:0]  wait_n;
    logic        e_irq;
    logic [31:0] e_cnt;
    logic        e_ip;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0100, 28'h000_0105, 1'b1, 8'd10, 1'b1, 32'h0000_010A, 1'b1},
    '{32'h0000_0100, 28'h000_0114, 1'b1, 8'd10, 1'b0, 32'h0000_010A, 1'b0},
    '{32'h3000_0000, 28'h000_0004, 1'b1, 8'd8,  1'b1, 32'h3000_0008, 1'b1},
    '{32'h0000_0050, 28'h000_0052, 1'b0, 8'd5,  1'b0, 32'h0000_0055, 1'b1},
    '{32'hFFFF_FFFE, 28'h000_0001, 1'b1, 8'd4,  1'b1, 32'h0000_0002, 1'b1},
    '{32'h0000_0777, 28'h000_0777, 1'b1, 8'd0,  1'b1, 32'h0000_0777, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel; reg_we = 1'b0;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(1'b0, v); chk("R1 count", v, 32'h0);
    rd(1'b1, v); chk("R1 mode", v, 32'h0);

    // Table of continuous-mode cases (R2, R4, R5, R6, R11)
    for (int k = 0; k < 6; k++) begin
      wr(1'b0, VECS[k].c0);
      wr(1'b1, {2'b11, VECS[k].en, 1'b0, VECS[k].per});
      tick(int'(VECS[k].wait_n));
      rd(1'b0, v);
      chk("R6 R2 count", v, VECS[k].e_cnt);
      chk("R5 irq", {31'b0, irq}, {31'b0, VECS[k].e_irq});
      rd(1'b1, v);
      chk("R4 pending", {31'b0, v[28]}, {31'b0, VECS[k].e_ip});
      wr(1'b1, 32'h0);
    end

    // R3 disabled mode freezes the count, no match at period == count
    wr(1'b0, 32'h0000_1234);
    wr(1'b1, 32'h2000_1234);
    tick(5);
    rd(1'b0, v); chk("R3 count frozen", v, 32'h0000_1234);
    chk("R3 irq", {31'b0, irq}, 32'h0);
    rd(1'b1, v); chk("R3 no pending", v, 32'h2000_1234);

    // R7 restart mode, period 3 -> cycle of 4
    wr(1'b0, 32'h0);
    wr(1'b1, 32'h6000_0003);
    tick(4);
    chk("R7 irq", {31'b0, irq}, 32'h1);
    rd(1'b0, v); chk("R7 count cleared", v, 32'h0);
    tick(3);
    rd(1'b0, v); chk("R7 count cleared again", v, 32'h0);
    wr(1'b1, 32'h0);

    // R8 one-shot mode
    wr(1'b0, 32'h0000_0010);
    wr(1'b1, 32'hA000_0013);
    tick(10);
    rd(1'b0, v); chk("R8 count held", v, 32'h0000_0013);
    chk("R8 irq", {31'b0, irq}, 32'h1);
    rd(1'b1, v); chk("R8 mode to off", v, 32'h3000_0013);

    // R10 acknowledge with continuous code only
    wr(1'b1, 32'hC000_0000);
    chk("R10 irq dropped", {31'b0, irq}, 32'h0);
    tick(3);
    rd(1'b0, v); chk("R10 count runs", v, 32'h0000_0016);
    rd(1'b1, v); chk("R10 mode", v, 32'hC000_0000);

    // R9 writing 1 to pending does not set it
    wr(1'b1, 32'hF000_0500);
    chk("R9 irq after write-1", {31'b0, irq}, 32'h0);
    rd(1'b1, v); chk("R9 pending unchanged", v, 32'hE000_0500);

    // R9 match wins over a clearing write on the same edge
    wr(1'b1, 32'hE000_0201);
    wr(1'b0, 32'h0000_0200);
    tick(1);
    wr(1'b1, 32'hE0AB_CDEF);
    chk("R9 irq match wins", {31'b0, irq}, 32'h1);
    rd(1'b1, v); chk("R9 pending kept", v, 32'hF0AB_CDEF);

    // R2 load while running, R11 registered read
    wr(1'b0, 32'h0000_5000);
    rd(1'b0, v); chk("R2 R11 loaded count", v, 32'h0000_5000);
    rd(1'b0, v); chk("R2 R11 next count", v, 32'h0000_5001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule